// File: doc/BRIEF.md
# CPU/PCI Bus Ownership Arbiter

This block decides who owns a shared bus: the host CPU or a PCI master. Each requester raises a request line. The arbiter holds a registered owner and drives a one-hot pair of grants. When neither side is requesting, the grant rests on the CPU. Ownership can change only at an arbitration point or when a watchdog forces one.

Configuration inputs control the behaviour:
- A policy bit selects fixed PCI priority or alternation between the two requesters.
- A mode bit selects whether a PCI owner is re-arbitrated only when it drops its request, or also at the end of every PCI transaction (the FRAME# line returning high).
- A rotation control guarantees the CPU a turn after 1, 2 or 3 consecutive PCI grants.

Two watchdogs protect the bus from a PCI owner that keeps it too long. The first bounds the tenure to a programmable multiple of 32 clocks. The second catches a master that never starts a transaction within 16 clocks of its grant. Either watchdog raises a one-cycle forced re-arbitration pulse, and the bus returns to the CPU.

Top module: `bus_owner_arbiter`

## Requirements
- R1: Exactly one of `gnt_cpu` and `gnt_pci` is high in every cycle; after reset `gnt_cpu` is high and `force_rearb` is low.
- R2: When neither `cpu_req` nor `pci_req` is high at a clock edge, `gnt_cpu` is high in the following cycle (parking on the CPU).
- R3: With `cfg_fair`=0 and rotation inactive, a PCI owner reaching an arbitration point while both requests are high keeps the bus.
- R4: With `cfg_fair`=1 and rotation inactive, a PCI owner reaching an arbitration point while both requests are high hands the bus to the CPU in the next cycle.
- R5: The owner changes only at an arbitration point or a forced arbitration. A CPU owner reaches an arbitration point when `cpu_req` is low. A PCI owner reaches one when `pci_req` is low. When `cfg_frame_mode`=1, a PCI owner also reaches one at a FRAME# end.
- R6: A FRAME# end is a cycle in which `frame_n` is high after having been low in the previous cycle. It is an arbitration point for a PCI owner only when `cfg_frame_mode`=1.
- R7: The tenure counter is 0 in the first cycle of each PCI grant. When `cfg_tenure` is non-zero, `force_rearb` pulses in the cycle where the counter equals `cfg_tenure`×32−1. When `cfg_tenure` is zero, this watchdog never fires.
- R8: With `cfg_broken_en`=1, `force_rearb` pulses in the 16th cycle of a PCI grant if `frame_n` has stayed high through all 16 cycles.
- R9: Rotation is active when `cfg_rot_en`=1 and `cfg_rot_ctl` is N=1, 2 or 3. A count of PCI grant decisions (saturating at 3) clears whenever the CPU is granted. When both request at a PCI arbitration point, the CPU wins once the count has reached N; otherwise the PCI master is granted again.
- R10: With `cfg_rot_en`=0 or `cfg_rot_ctl`=0, the choice follows `cfg_fair` as in R3 and R4.
- R11: `force_rearb` is high only while the PCI master owns the bus, and the CPU owns the bus in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cpu_req | input | 1 | CPU wants the bus |
| pci_req | input | 1 | PCI master wants the bus |
| frame_n | input | 1 | PCI FRAME#, low while a transaction is in progress |
| cfg_fair | input | 1 | 0: PCI has priority, 1: alternate between requesters |
| cfg_frame_mode | input | 1 | 0: re-arbitrate on request release, 1: also at each FRAME# end |
| cfg_tenure | input | 4 | Tenure limit in units of 32 clocks, 0 disables |
| cfg_broken_en | input | 1 | Enables the 16-clock broken-master watchdog |
| cfg_rot_en | input | 1 | Enables CPU rotation |
| cfg_rot_ctl | input | 2 | Number of PCI grants before a CPU turn (0 disables) |
| gnt_cpu | output | 1 | Bus granted to the CPU |
| gnt_pci | output | 1 | Bus granted to the PCI master |
| force_rearb | output | 1 | One-cycle pulse when a watchdog forces arbitration |

## Verification
The assertions check these properties on every cycle:
- the grants stay one-hot;
- an idle bus parks on the CPU;
- ownership holds between arbitration points;
- a forced pulse occurs only under PCI ownership and hands the bus to the CPU;
- the priority, fair and single-grant rotation choices are made at a PCI arbitration point.

Some behaviours depend on history and are shown only by the bench's reference model across its configuration scenarios:
- the exact cycle of the 32-clock tenure timeout and of the 16-clock broken-master timeout;
- the grant counts of 2 and 3 in rotation;
- the disabling of rotation by either control.

// File: rtl/arb_pkg.sv
package arb_pkg;
  localparam int LIM_W      = 4;
  localparam int UNIT_LG    = 5;
  localparam int CNT_W      = LIM_W + UNIT_LG;
  localparam int BROKEN_CYC = 16;
  localparam int ROT_W      = 2;

  typedef enum logic {OWN_CPU = 1'b0, OWN_PCI = 1'b1} owner_e;

  // last cycle index of a tenure of lim units
  function automatic logic [CNT_W-1:0] tenure_last(input logic [LIM_W-1:0] lim);
    return {lim, {UNIT_LG{1'b0}}} - CNT_W'(1);
  endfunction

  // owner chosen at an arbitration point
  function automatic owner_e pick_owner(input logic cpu_r, input logic pci_r,
                                        input owner_e cur, input logic fair,
                                        input logic rot_act, input logic rot_hit);
    if (!pci_r) return OWN_CPU;
    if (!cpu_r) return OWN_PCI;
    if (rot_act) return rot_hit ? OWN_CPU : OWN_PCI;
    if (fair) return (cur == OWN_PCI) ? OWN_CPU : OWN_PCI;
    return OWN_PCI;
  endfunction
endpackage

// File: rtl/arb_release.sv
module arb_release
  import arb_pkg::*;
(
  input  logic   clk,
  input  logic   rst_n,
  input  logic   frame_n,
  input  logic   frame_mode,
  input  logic   cpu_req,
  input  logic   pci_req,
  input  owner_e owner,
  output logic   frame_end,
  output logic   release_pt
);
  logic frame_q;

  always_ff @(posedge clk) begin
    if (!rst_n) frame_q <= 1'b1;
    else        frame_q <= frame_n;
  end

  assign frame_end = !frame_q && frame_n;

  always_comb begin
    if (owner == OWN_PCI) release_pt = !pci_req || (frame_mode && frame_end);
    else                  release_pt = !cpu_req;
  end
endmodule

// File: rtl/arb_timers.sv
module arb_timers
  import arb_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  owner_e           owner,
  input  logic             start_pci,
  input  logic             frame_n,
  input  logic [LIM_W-1:0] lim,
  input  logic             broken_en,
  output logic             force_ten,
  output logic             force_brk
);
  localparam logic [CNT_W-1:0] CNT_MAX  = {CNT_W{1'b1}};
  localparam logic [CNT_W-1:0] BRK_LAST = CNT_W'(BROKEN_CYC - 1);

  logic [CNT_W-1:0] cnt_q;
  logic             seen_q;
  logic             is_pci;

  assign is_pci = (owner == OWN_PCI);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      seen_q <= 1'b0;
    end else if (start_pci) begin
      cnt_q  <= '0;
      seen_q <= 1'b0;
    end else if (is_pci) begin
      if (cnt_q != CNT_MAX) cnt_q <= cnt_q + CNT_W'(1);
      seen_q <= seen_q | !frame_n;
    end
  end

  assign force_ten = is_pci && (lim != '0) && (cnt_q == tenure_last(lim));
  assign force_brk = is_pci && broken_en && !seen_q && frame_n && (cnt_q == BRK_LAST);
endmodule

// File: rtl/arb_rotation.sv
module arb_rotation
  import arb_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             arb_fire,
  input  owner_e           next_owner,
  input  logic             rot_en,
  input  logic [ROT_W-1:0] rot_ctl,
  output logic             rot_act,
  output logic             rot_hit
);
  logic [ROT_W-1:0] pci_cnt_q;

  always_ff @(posedge clk) begin
    if (!rst_n) pci_cnt_q <= '0;
    else if (arb_fire) begin
      if (next_owner == OWN_CPU)       pci_cnt_q <= '0;
      else if (pci_cnt_q != '1)        pci_cnt_q <= pci_cnt_q + ROT_W'(1);
    end
  end

  assign rot_act = rot_en && (rot_ctl != '0);
  assign rot_hit = (pci_cnt_q >= rot_ctl);
endmodule

// File: rtl/bus_owner_arbiter.sv
module bus_owner_arbiter
  import arb_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cpu_req,
  input  logic             pci_req,
  input  logic             frame_n,
  input  logic             cfg_fair,
  input  logic             cfg_frame_mode,
  input  logic [LIM_W-1:0] cfg_tenure,
  input  logic             cfg_broken_en,
  input  logic             cfg_rot_en,
  input  logic [ROT_W-1:0] cfg_rot_ctl,
  output logic             gnt_cpu,
  output logic             gnt_pci,
  output logic             force_rearb
);
  owner_e owner_q;
  owner_e next_owner;
  logic   frame_end, release_pt;
  logic   force_ten, force_brk;
  logic   rot_act, rot_hit;
  logic   arb_fire, start_pci;

  arb_release u_rel (
    .clk(clk), .rst_n(rst_n), .frame_n(frame_n), .frame_mode(cfg_frame_mode),
    .cpu_req(cpu_req), .pci_req(pci_req), .owner(owner_q),
    .frame_end(frame_end), .release_pt(release_pt)
  );

  arb_timers u_tmr (
    .clk(clk), .rst_n(rst_n), .owner(owner_q), .start_pci(start_pci),
    .frame_n(frame_n), .lim(cfg_tenure), .broken_en(cfg_broken_en),
    .force_ten(force_ten), .force_brk(force_brk)
  );

  arb_rotation u_rot (
    .clk(clk), .rst_n(rst_n), .arb_fire(arb_fire), .next_owner(next_owner),
    .rot_en(cfg_rot_en), .rot_ctl(cfg_rot_ctl), .rot_act(rot_act), .rot_hit(rot_hit)
  );

  assign force_rearb = force_ten || force_brk;
  assign arb_fire    = release_pt || force_rearb;
  assign next_owner  = force_rearb ? OWN_CPU
                     : pick_owner(cpu_req, pci_req, owner_q, cfg_fair, rot_act, rot_hit);
  assign start_pci   = arb_fire && (next_owner == OWN_PCI);

  always_ff @(posedge clk) begin
    if (!rst_n)        owner_q <= OWN_CPU;
    else if (arb_fire) owner_q <= next_owner;
  end

  assign gnt_cpu = (owner_q == OWN_CPU);
  assign gnt_pci = (owner_q == OWN_PCI);
endmodule

// File: rtl/arb_checker.sv
module arb_checker
  import arb_pkg::*;
(
  input logic             clk,
  input logic             rst_n,
  input logic             cpu_req,
  input logic             pci_req,
  input logic             cfg_fair,
  input logic             cfg_rot_en,
  input logic [ROT_W-1:0] cfg_rot_ctl,
  input logic             gnt_cpu,
  input logic             gnt_pci,
  input logic             force_rearb,
  input logic             arb_fire
);
  logic rot_on;
  assign rot_on = cfg_rot_en && (cfg_rot_ctl != '0);

  AST_GRANT_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
    $countones({gnt_cpu, gnt_pci}) == 1);  // R1
  AST_IDLE_PARKS: assert property (@(posedge clk) disable iff (!rst_n)
    (!cpu_req && !pci_req) |=> gnt_cpu);  // R2
  AST_PCI_PRIORITY: assert property (@(posedge clk) disable iff (!rst_n)
    (!cfg_fair && !rot_on && gnt_pci && arb_fire && !force_rearb && cpu_req && pci_req) |=> gnt_pci);  // R3
  AST_FAIR_ALTERNATE: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_fair && !rot_on && gnt_pci && arb_fire && cpu_req && pci_req) |=> gnt_cpu);  // R4
  AST_HOLD_BETWEEN_POINTS: assert property (@(posedge clk) disable iff (!rst_n)
    !arb_fire |=> $stable({gnt_cpu, gnt_pci}));  // R5
  AST_ROT_ONE_GRANT: assert property (@(posedge clk) disable iff (!rst_n)
    (rot_on && cfg_rot_ctl == 2'd1 && gnt_pci && arb_fire && cpu_req && pci_req) |=> gnt_cpu);  // R9
  AST_FORCE_WHILE_PCI: assert property (@(posedge clk) disable iff (!rst_n)
    force_rearb |-> gnt_pci);  // R11
  AST_FORCE_TO_CPU: assert property (@(posedge clk) disable iff (!rst_n)
    force_rearb |=> gnt_cpu);  // R11
endmodule

bind bus_owner_arbiter arb_checker chk_i (
  .clk(clk), .rst_n(rst_n), .cpu_req(cpu_req), .pci_req(pci_req),
  .cfg_fair(cfg_fair), .cfg_rot_en(cfg_rot_en), .cfg_rot_ctl(cfg_rot_ctl),
  .gnt_cpu(gnt_cpu), .gnt_pci(gnt_pci), .force_rearb(force_rearb), .arb_fire(arb_fire)
);

// File: tb/bus_owner_arbiter_tb.sv
module bus_owner_arbiter_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cpu_req = 0, pci_req = 0, frame_n = 1;
  logic cfg_fair = 0, cfg_frame_mode = 0, cfg_broken_en = 0, cfg_rot_en = 0;
  logic [3:0] cfg_tenure = 0;
  logic [1:0] cfg_rot_ctl = 0;
  logic gnt_cpu, gnt_pci, force_rearb;

  int errors = 0, checks = 0, forces = 0;
  bit done = 0;

  // behavioural reference state
  bit m_pci, m_seen, m_fprev;
  int m_cnt, m_rot;

  always #5 clk = ~clk;

  bus_owner_arbiter dut_i (
    .clk(clk), .rst_n(rst_n), .cpu_req(cpu_req), .pci_req(pci_req), .frame_n(frame_n),
    .cfg_fair(cfg_fair), .cfg_frame_mode(cfg_frame_mode), .cfg_tenure(cfg_tenure),
    .cfg_broken_en(cfg_broken_en), .cfg_rot_en(cfg_rot_en), .cfg_rot_ctl(cfg_rot_ctl),
    .gnt_cpu(gnt_cpu), .gnt_pci(gnt_pci), .force_rearb(force_rearb)
  );

  task automatic chk(input bit ok, input string tag, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
    end
  endtask

  task automatic do_reset();
    rst_n = 0; cpu_req = 0; pci_req = 0; frame_n = 1;
    repeat (3) @(negedge clk);
    rst_n = 1;
    m_pci = 0; m_seen = 0; m_fprev = 1; m_cnt = 0; m_rot = 0;
    #2;
    chk(gnt_cpu && !gnt_pci && !force_rearb, "R1", "reset grants/force",
        {gnt_cpu, gnt_pci, force_rearb}, 3'b100);
  endtask

  // one cycle: inputs already applied; compare then advance model
  task automatic model_cycle(input string tag);
    bit exp_force, rel, fire, nxt, rot_on;
    int lastc;
    lastc = int'(cfg_tenure) * 32 - 1;
    exp_force = m_pci && ((cfg_tenure != 0 && m_cnt == lastc) ||
                          (cfg_broken_en && !m_seen && frame_n && m_cnt == 15));
    chk(gnt_pci == m_pci && gnt_cpu == !m_pci && force_rearb == exp_force, tag,
        "gnt_pci/gnt_cpu/force", {gnt_pci, gnt_cpu, force_rearb}, {m_pci, !m_pci, exp_force});
    if (force_rearb) forces++;
    rel = m_pci ? (!pci_req || (cfg_frame_mode && !m_fprev && frame_n)) : !cpu_req;
    fire = rel || exp_force;
    rot_on = cfg_rot_en && cfg_rot_ctl != 0;
    nxt = m_pci;
    if (fire) begin
      if (exp_force || !pci_req) nxt = 0;
      else if (!cpu_req) nxt = 1;
      else if (rot_on) nxt = (m_rot >= cfg_rot_ctl) ? 0 : 1;
      else if (cfg_fair) nxt = !m_pci;
      else nxt = 1;
      m_rot = nxt ? ((m_rot < 3) ? m_rot + 1 : 3) : 0;
    end
    if (fire && nxt) begin
      m_cnt = 0; m_seen = 0;
    end else if (m_pci) begin
      if (m_cnt < 511) m_cnt++;
      if (!frame_n) m_seen = 1;
    end
    m_fprev = frame_n;
    if (fire) m_pci = nxt;
  endtask

  task automatic run_phase(input string tag, input int ncyc, input int cpu_pct,
                           input int pci_pct, input bit no_frame);
    do_reset();
    for (int i = 0; i < ncyc; i++) begin
      @(negedge clk);
      #1;
      cpu_req = ($urandom_range(99, 0) < cpu_pct);
      pci_req = ($urandom_range(99, 0) < pci_pct);
      frame_n = no_frame ? 1'b1 : !(gnt_pci && pci_req && ($urandom_range(3, 0) != 0));
      #1;
      model_cycle(tag);
    end
  endtask

  task automatic set_cfg(input bit fair, input bit fmode, input int ten, input bit brk,
                         input bit ren, input int rctl);
    cfg_fair = fair; cfg_frame_mode = fmode; cfg_tenure = 4'(ten);
    cfg_broken_en = brk; cfg_rot_en = ren; cfg_rot_ctl = 2'(rctl);
  endtask

  initial begin
    // R3 R5 R2: priority, request-release mode
    set_cfg(0, 0, 0, 0, 0, 0);
    run_phase("R3", 400, 60, 60, 0);
    // R2 directed: idle bus parks on CPU
    @(negedge clk); #1; cpu_req = 0; pci_req = 0; frame_n = 1; #1; model_cycle("R2");
    @(negedge clk); #1; #1; model_cycle("R2");
    chk(gnt_cpu == 1, "R2", "parked grant", gnt_cpu, 1);
    // R4 R6: fair, frame mode
    set_cfg(1, 1, 0, 0, 0, 0);
    run_phase("R4", 400, 70, 80, 0);
    set_cfg(0, 1, 0, 0, 0, 0);
    run_phase("R6", 400, 70, 80, 0);
    // R9: rotation counts 1..3
    for (int n = 1; n <= 3; n++) begin
      set_cfg(0, 1, 0, 0, 1, n);
      run_phase("R9", 400, 80, 90, 0);
    end
    // R10: rotation disabled either way
    set_cfg(1, 1, 0, 0, 1, 0);
    run_phase("R10", 300, 80, 90, 0);
    set_cfg(0, 1, 0, 0, 0, 2);
    run_phase("R10", 300, 80, 90, 0);
    // R7: tenure watchdog, PCI never releases
    forces = 0;
    set_cfg(0, 0, 1, 0, 0, 0);
    run_phase("R7", 300, 0, 100, 0);
    chk(forces > 0, "R7", "tenure forces seen", forces, 1);
    forces = 0;
    set_cfg(0, 0, 0, 0, 0, 0);
    run_phase("R7", 200, 0, 100, 0);
    chk(forces == 0, "R7", "tenure disabled forces", forces, 0);
    forces = 0;
    set_cfg(1, 0, 2, 0, 0, 0);
    run_phase("R7", 400, 30, 100, 0);
    // R8 R11: broken master never drives FRAME#
    forces = 0;
    set_cfg(0, 0, 0, 1, 0, 0);
    run_phase("R8", 300, 50, 100, 1);
    chk(forces > 0, "R8", "broken forces seen", forces, 1);
    set_cfg(1, 1, 3, 1, 1, 2);
    run_phase("R11", 500, 60, 90, 0);
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #(200000 * 10);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired actual=0 expected=1");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule